// File: doc/BRIEF.md
# ALU with status flags

A purely combinational arithmetic and logic unit. Two operands of `WIDTH` bits (32 by default) and a 4-bit operation code select one of fourteen operations: addition, subtraction in either direction, low-half multiplication, unsigned division, reversed unsigned modulo, five bitwise operations and three logical operations. Codes outside that map fall back to addition. The result appears on the same evaluation as the inputs; nothing is stored.

Alongside the result the unit reports four status flags: zero, negative, unsigned carry and signed overflow. It also reports a three-way comparison of the two operands. The comparison always runs, whatever operation is selected. A single shared adder serves addition and both subtraction directions. Division and modulo by zero return fixed, defined values, so the datapath never produces an undefined word.

Top module: `alu_status`

## Requirements
- R1: Code 0 gives `result = (a + b) mod 2^WIDTH`, and `flag_carry` is bit WIDTH of the sum taken at WIDTH+1 bits. For example, all-ones plus one gives result 0 with carry 1.
- R2: Code 1 gives `a - b` and code 2 gives `b - a`, both modulo 2^WIDTH. For these codes `flag_carry` is 1 exactly when the minuend is not smaller than the subtrahend as unsigned numbers, so it is the inverted borrow.
- R3: `flag_ovf` is 1 for codes 0, 1, 2, 14 and 15 exactly when the two's-complement result of that add or subtract falls outside the signed WIDTH-bit range. For codes 3 to 13, both `flag_ovf` and `flag_carry` are 0.
- R4: Code 3 gives the low WIDTH bits of the unsigned product `a * b`.
- R5: Code 4 gives the unsigned quotient `a / b`, or all ones when b is 0. Code 5 gives the unsigned remainder `b % a`, or b itself when a is 0.
- R6: Codes 6 to 10 give, bit by bit, `~a`, `a & b`, `a | b`, `a ^ b` and `~(a ^ b)`.
- R7: Codes 11, 12 and 13 give the logical NOT of a, the logical AND of a and b, and the logical OR of a and b. An operand counts as true when it is non-zero. The result is 1 or 0 in bit 0, with all upper bits 0.
- R8: `flag_zero` is 1 exactly when every result bit is 0, for every code.
- R9: `flag_neg` equals result bit WIDTH-1 for codes 1 and 2, and is 0 for all other codes.
- R10: Exactly one of `cmp_lt`, `cmp_gt` and `cmp_eq` is 1 at all times. They report a<b, a>b and a==b, with both operands read as two's-complement signed numbers, independent of the code.
- R11: Codes 14 and 15 behave exactly like code 0 in the result and in all flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | WIDTH | First operand |
| opnd_b | input | WIDTH | Second operand |
| op_sel | input | 4 | Operation code |
| result | output | WIDTH | Operation result |
| flag_zero | output | 1 | Result is all zeros |
| flag_neg | output | 1 | Sign of a subtraction result |
| flag_carry | output | 1 | Unsigned carry / not-borrow of add and subtract |
| flag_ovf | output | 1 | Signed overflow of add and subtract |
| cmp_lt | output | 1 | a < b, signed |
| cmp_gt | output | 1 | a > b, signed |
| cmp_eq | output | 1 | a == b |

## Verification
Every output is produced on the same evaluation, so the status logic and the operand comparator always act in the same cycle as the selected operation. The interesting cases are where they coincide: a subtraction of equal operands must raise `cmp_eq`, `flag_zero` and the not-borrow carry together, and a wrapping addition such as all-ones plus one must raise zero and carry at once. A 6-bit copy of the unit is swept over every operand pair under all sixteen codes. Directed 32-bit vectors target the sign and wrap boundaries. Each output is judged against values the bench derives with 64-bit integer arithmetic and explicit signed range tests.

// File: rtl/alu_pkg.sv
package alu_pkg;

   parameter int OP_W = 4;

   typedef enum logic [OP_W-1:0] {
      OP_ADD  = 4'd0,
      OP_SUB  = 4'd1,
      OP_RSUB = 4'd2,
      OP_MUL  = 4'd3,
      OP_DIV  = 4'd4,
      OP_RMOD = 4'd5,
      OP_NOT  = 4'd6,
      OP_AND  = 4'd7,
      OP_OR   = 4'd8,
      OP_XOR  = 4'd9,
      OP_XNOR = 4'd10,
      OP_LNOT = 4'd11,
      OP_LAND = 4'd12,
      OP_LOR  = 4'd13
   } alu_op_e;

   // Codes handled by the logic unit rather than the arithmetic unit
   function automatic logic is_logic_op(input logic [OP_W-1:0] op);
      return (op >= OP_NOT) && (op <= OP_LOR);
   endfunction

   // Codes whose negative flag is meaningful
   function automatic logic is_sub_op(input logic [OP_W-1:0] op);
      return (op == OP_SUB) || (op == OP_RSUB);
   endfunction

endpackage

// File: rtl/alu_arith.sv
module alu_arith
   import alu_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic [OP_W-1:0]  op,
   output logic [WIDTH-1:0] res,
   output logic             carry,
   output logic             ovf
);

   localparam int MSB = WIDTH - 1;

   logic [WIDTH-1:0] add_x;
   logic [WIDTH-1:0] add_y;
   logic             add_cin;
   logic [WIDTH:0]   add_sum;
   logic             add_ovf;
   logic [WIDTH-1:0] prod;
   logic [WIDTH-1:0] quot;
   logic [WIDTH-1:0] rem;

   // Shared adder: subtraction is x + ~y + 1
   always_comb begin
      add_x   = a;
      add_y   = b;
      add_cin = 1'b0;
      case (op)
         OP_SUB: begin
            add_x   = a;
            add_y   = ~b;
            add_cin = 1'b1;
         end
         OP_RSUB: begin
            add_x   = b;
            add_y   = ~a;
            add_cin = 1'b1;
         end
         default: begin
            add_x   = a;
            add_y   = b;
            add_cin = 1'b0;
         end
      endcase
   end

   assign add_sum = {1'b0, add_x} + {1'b0, add_y} + {{WIDTH{1'b0}}, add_cin};
   assign add_ovf = (add_x[MSB] == add_y[MSB]) && (add_sum[MSB] != add_x[MSB]);

   assign prod = a * b;
   assign quot = (b == '0) ? '1 : (a / b);
   assign rem  = (a == '0) ? b  : (b % a);

   always_comb begin
      res   = add_sum[MSB:0];
      carry = add_sum[WIDTH];
      ovf   = add_ovf;
      case (op)
         OP_MUL: begin
            res   = prod;
            carry = 1'b0;
            ovf   = 1'b0;
         end
         OP_DIV: begin
            res   = quot;
            carry = 1'b0;
            ovf   = 1'b0;
         end
         OP_RMOD: begin
            res   = rem;
            carry = 1'b0;
            ovf   = 1'b0;
         end
         OP_NOT, OP_AND, OP_OR, OP_XOR, OP_XNOR, OP_LNOT, OP_LAND, OP_LOR: begin
            res   = '0;
            carry = 1'b0;
            ovf   = 1'b0;
         end
         default: begin
            res   = add_sum[MSB:0];
            carry = add_sum[WIDTH];
            ovf   = add_ovf;
         end
      endcase
   end

endmodule

// File: rtl/alu_logic.sv
module alu_logic
   import alu_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic [OP_W-1:0]  op,
   output logic [WIDTH-1:0] res
);

   logic sel_not, sel_and, sel_or, sel_xor, sel_xnor;
   logic sel_lnot, sel_land, sel_lor, sel_bool;
   logic a_true, b_true, bool_val;
   logic [WIDTH-1:0] bw;

   assign sel_not  = (op == OP_NOT);
   assign sel_and  = (op == OP_AND);
   assign sel_or   = (op == OP_OR);
   assign sel_xor  = (op == OP_XOR);
   assign sel_xnor = (op == OP_XNOR);
   assign sel_lnot = (op == OP_LNOT);
   assign sel_land = (op == OP_LAND);
   assign sel_lor  = (op == OP_LOR);
   assign sel_bool = sel_lnot | sel_land | sel_lor;

   // One AND-OR cell per bit position
   for (genvar i = 0; i < WIDTH; i++) begin : g_cell
      assign bw[i] = (sel_not  & ~a[i])
                   | (sel_and  & (a[i] & b[i]))
                   | (sel_or   & (a[i] | b[i]))
                   | (sel_xor  & (a[i] ^ b[i]))
                   | (sel_xnor & ~(a[i] ^ b[i]));
   end

   assign a_true = |a;
   assign b_true = |b;

   always_comb begin
      bool_val = 1'b0;
      if (sel_lnot)
         bool_val = ~a_true;
      else if (sel_land)
         bool_val = a_true & b_true;
      else if (sel_lor)
         bool_val = a_true | b_true;
   end

   assign res = sel_bool ? {{(WIDTH-1){1'b0}}, bool_val} : bw;

endmodule

// File: rtl/alu_compare.sv
module alu_compare #(
   parameter int WIDTH      = 32,
   parameter bit SIGNED_CMP = 1'b1
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   output logic             lt,
   output logic             gt,
   output logic             eq
);

   if (SIGNED_CMP) begin : g_signed
      assign lt = $signed(a) < $signed(b);
      assign gt = $signed(a) > $signed(b);
   end else begin : g_unsigned
      assign lt = a < b;
      assign gt = a > b;
   end

   assign eq = (a == b);

endmodule

// File: rtl/alu_status.sv
module alu_status
   import alu_pkg::*;
#(
   parameter int WIDTH      = 32,
   parameter bit SIGNED_CMP = 1'b1
) (
   input  logic [WIDTH-1:0] opnd_a,
   input  logic [WIDTH-1:0] opnd_b,
   input  logic [3:0]       op_sel,
   output logic [WIDTH-1:0] result,
   output logic             flag_zero,
   output logic             flag_neg,
   output logic             flag_carry,
   output logic             flag_ovf,
   output logic             cmp_lt,
   output logic             cmp_gt,
   output logic             cmp_eq
);

   localparam int MSB = WIDTH - 1;

   if (WIDTH < 2) begin : g_bad_width
      $error("alu_status: WIDTH must be at least 2");
   end
   if (OP_W != 4) begin : g_bad_opw
      $error("alu_status: operation code must be 4 bits");
   end

   logic [WIDTH-1:0] arith_res;
   logic [WIDTH-1:0] logic_res;
   logic             arith_carry;
   logic             arith_ovf;
   logic             use_logic;

   alu_arith #(.WIDTH(WIDTH)) u_arith (
      .a     (opnd_a),
      .b     (opnd_b),
      .op    (op_sel),
      .res   (arith_res),
      .carry (arith_carry),
      .ovf   (arith_ovf)
   );

   alu_logic #(.WIDTH(WIDTH)) u_logic (
      .a   (opnd_a),
      .b   (opnd_b),
      .op  (op_sel),
      .res (logic_res)
   );

   alu_compare #(.WIDTH(WIDTH), .SIGNED_CMP(SIGNED_CMP)) u_cmp (
      .a  (opnd_a),
      .b  (opnd_b),
      .lt (cmp_lt),
      .gt (cmp_gt),
      .eq (cmp_eq)
   );

   assign use_logic  = is_logic_op(op_sel);
   assign result     = use_logic ? logic_res : arith_res;
   assign flag_zero  = ~|result;
   assign flag_neg   = is_sub_op(op_sel) & result[MSB];
   assign flag_carry = arith_carry;
   assign flag_ovf   = arith_ovf;

endmodule

// File: rtl/alu_status_chk.sv
module alu_status_chk #(
   parameter int WIDTH = 32
) (
   input logic [WIDTH-1:0] opnd_a,
   input logic [WIDTH-1:0] opnd_b,
   input logic [3:0]       op_sel,
   input logic [WIDTH-1:0] result,
   input logic             flag_zero,
   input logic             flag_neg,
   input logic             flag_carry,
   input logic             flag_ovf,
   input logic             cmp_lt,
   input logic             cmp_gt,
   input logic             cmp_eq
);

   always_comb begin
      p_cmp_onehot_r10: assert ($countones({cmp_lt, cmp_gt, cmp_eq}) == 1)
         else $error("comparator outputs not exclusive");
      p_no_overflow_r3: assert (!((op_sel >= 4'd3) && (op_sel <= 4'd13)) || (!flag_ovf && !flag_carry))
         else $error("carry or overflow outside add/subtract");
      p_neg_gate_r9: assert (!flag_neg || (op_sel == 4'd1) || (op_sel == 4'd2))
         else $error("negative flag outside subtract");
      p_bool_result_r7: assert (!((op_sel >= 4'd11) && (op_sel <= 4'd13)) || (result[WIDTH-1:1] == '0))
         else $error("logical result wider than one bit");
      p_div_zero_r5: assert (!((op_sel == 4'd4) && (opnd_b == '0)) || (&result))
         else $error("divide by zero not all ones");
      p_eq_sub_zero_r8: assert (!(cmp_eq && (op_sel == 4'd1)) || (flag_zero && flag_carry))
         else $error("equal operands subtract not zero with carry");
   end

endmodule

bind alu_status alu_status_chk #(.WIDTH(WIDTH)) u_chk (
   .opnd_a     (opnd_a),
   .opnd_b     (opnd_b),
   .op_sel     (op_sel),
   .result     (result),
   .flag_zero  (flag_zero),
   .flag_neg   (flag_neg),
   .flag_carry (flag_carry),
   .flag_ovf   (flag_ovf),
   .cmp_lt     (cmp_lt),
   .cmp_gt     (cmp_gt),
   .cmp_eq     (cmp_eq)
);

// File: tb/test_alu_status.sv
module test_alu_status;

   localparam int WB = 32;
   localparam int WS = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit done = 1'b0;

   logic [WB-1:0] b_a, b_b, b_res;
   logic [3:0]    b_op;
   logic          b_z, b_n, b_c, b_v, b_lt, b_gt, b_eq;

   logic [WS-1:0] s_a, s_b, s_res;
   logic [3:0]    s_op;
   logic          s_z, s_n, s_c, s_v, s_lt, s_gt, s_eq;

   alu_status #(.WIDTH(WB)) i_alu_status (
      .opnd_a(b_a), .opnd_b(b_b), .op_sel(b_op), .result(b_res),
      .flag_zero(b_z), .flag_neg(b_n), .flag_carry(b_c), .flag_ovf(b_v),
      .cmp_lt(b_lt), .cmp_gt(b_gt), .cmp_eq(b_eq)
   );

   alu_status #(.WIDTH(WS)) i_alu_status_small (
      .opnd_a(s_a), .opnd_b(s_b), .op_sel(s_op), .result(s_res),
      .flag_zero(s_z), .flag_neg(s_n), .flag_carry(s_c), .flag_ovf(s_v),
      .cmp_lt(s_lt), .cmp_gt(s_gt), .cmp_eq(s_eq)
   );

   function automatic longint to_signed(input int w, input longint unsigned v);
      if (((v >> (w - 1)) & 64'd1) != 0)
         return longint'(v) - (longint'(1) <<< w);
      return longint'(v);
   endfunction

   function automatic bit out_of_range(input int w, input longint s);
      longint hi = (longint'(1) <<< (w - 1)) - 1;
      longint lo = -(longint'(1) <<< (w - 1));
      return (s > hi) || (s < lo);
   endfunction

   function automatic string res_tag(input int op);
      case (op)
         0: return "R1";
         1, 2: return "R2";
         3: return "R4";
         4, 5: return "R5";
         6, 7, 8, 9, 10: return "R6";
         11, 12, 13: return "R7";
         default: return "R11";
      endcase
   endfunction

   task automatic check(input string tag, input string what, input int op,
                        input longint unsigned act, input longint unsigned exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s op=%0d actual=%0h expected=%0h", tag, what, op, act, exp);
      end
   endtask

   // Reference computed from the requirements with 64-bit arithmetic
   task automatic judge(input int w, input longint unsigned a, input longint unsigned b, input int op,
                        input longint unsigned r_act, input bit z, input bit n, input bit c,
                        input bit v, input bit lt, input bit gt, input bit eq);
      longint unsigned m = (w == 64) ? '1 : ((64'd1 << w) - 1);
      longint unsigned r;
      longint sa = to_signed(w, a);
      longint sb = to_signed(w, b);
      bit ec = 1'b0, ev = 1'b0, en;
      string ctag = "R3";
      case (op)
         1: begin r = (a - b) & m; ec = (a >= b); ev = out_of_range(w, sa - sb); ctag = "R2"; end
         2: begin r = (b - a) & m; ec = (b >= a); ev = out_of_range(w, sb - sa); ctag = "R2"; end
         3: r = (a * b) & m;
         4: r = (b == 0) ? m : (a / b);
         5: r = (a == 0) ? b : (b % a);
         6: r = (~a) & m;
         7: r = a & b;
         8: r = a | b;
         9: r = a ^ b;
         10: r = (~(a ^ b)) & m;
         11: r = (a == 0) ? 64'd1 : 64'd0;
         12: r = ((a != 0) && (b != 0)) ? 64'd1 : 64'd0;
         13: r = ((a != 0) || (b != 0)) ? 64'd1 : 64'd0;
         default: begin
            r = (a + b) & m; ec = (((a + b) >> w) & 64'd1) != 0;
            ev = out_of_range(w, sa + sb); ctag = (op == 0) ? "R1" : "R11";
         end
      endcase
      en = ((op == 1) || (op == 2)) && (((r >> (w - 1)) & 64'd1) != 0);
      check(res_tag(op), "result", op, r_act, r);
      check("R8", "zero", op, 64'(z), 64'(r == 0));
      check("R9", "neg", op, 64'(n), 64'(en));
      check(ctag, "carry", op, 64'(c), 64'(ec));
      check("R3", "ovf", op, 64'(v), 64'(ev));
      check("R10", "lt", op, 64'(lt), 64'(sa < sb));
      check("R10", "gt", op, 64'(gt), 64'(sa > sb));
      check("R10", "eq", op, 64'(eq), 64'(sa == sb));
   endtask

   task automatic run_big(input longint unsigned a, input longint unsigned b, input int op);
      b_a = a[WB-1:0]; b_b = b[WB-1:0]; b_op = op[3:0];
      @(negedge clk);
      judge(WB, a, b, op, 64'(b_res), b_z, b_n, b_c, b_v, b_lt, b_gt, b_eq);
   endtask

   task automatic run_small(input int a, input int b, input int op);
      s_a = a[WS-1:0]; s_b = b[WS-1:0]; s_op = op[3:0];
      @(negedge clk);
      judge(WS, longint'(a), longint'(b), op, 64'(s_res), s_z, s_n, s_c, s_v, s_lt, s_gt, s_eq);
   endtask

   longint unsigned va[12] = '{64'h0, 64'hFFFFFFFF, 64'h7FFFFFFF, 64'h80000000, 64'h80000000,
                               64'h1, 64'h12345678, 64'hFFFFFFFE, 64'h0, 64'hDEADBEEF,
                               64'h7FFFFFFF, 64'h64};
   longint unsigned vb[12] = '{64'h0, 64'h1, 64'h1, 64'h1, 64'h80000000,
                               64'hFFFFFFFF, 64'h12345678, 64'h0, 64'h5, 64'h0,
                               64'h80000000, 64'h7};

   initial begin
      b_a = '0; b_b = '0; b_op = '0;
      s_a = '0; s_b = '0; s_op = '0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      // Idle state: zero operands under code 0 give zero result, eq set (R8, R10)
      judge(WB, 0, 0, 0, 64'(b_res), b_z, b_n, b_c, b_v, b_lt, b_gt, b_eq);
      // Directed 32-bit boundaries: wrap carry R1, sign overflow R3, zero divisor R5
      for (int k = 0; k < 12; k++)
         for (int op = 0; op < 16; op++)
            run_big(va[k], vb[k], op);
      // Exhaustive sweep of the 6-bit copy under all codes, R11 included
      for (int op = 0; op < 16; op++)
         for (int a = 0; a < (1 << WS); a++)
            for (int b = 0; b < (1 << WS); b++)
               run_small(a, b, op);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 150000 && !done) begin
         errors = errors + 1;
         $display("FAIL watchdog expired after %0d cycles", cycles);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule